// File: doc/BRIEF.md
# PCI Type-0 Configuration Space Responder

This block answers configuration reads and writes for a small PCI serial function that exposes one or two I/O windows of 8 bytes each. A configuration request carries a byte offset, write data, byte enables and a read/write flag, qualified by a valid strobe. Reads return the addressed aligned dword one cycle later. Writes are filtered per offset: only the two I/O base registers and the interrupt line byte hold written values, and everything else keeps its reset contents.

The header holds fixed identity values: vendor/device and subsystem identity, a revision and a class code for a 16550-compatible serial controller, an interrupt pin hardwired to the first legacy pin, and no capability list. Base register sizing follows the usual software probe: an all-ones write reads back as the size mask of an 8-byte I/O window. The port-count parameter `NUM_PORTS` decides whether the second base register is live or reads as zero.

Top module: `cfg_space_resp`

## Requirements
- R1: After reset the dword at offset 0x00 reads 0x32534348, and the dword at offset 0x2C reads the same value.
- R2: The dword at offset 0x04 reads 0x02000001 (command 0x0001 in the low half, status 0x0200 in the high half), and writes to it are ignored.
- R3: The dword at offset 0x08 reads 0x07000210: revision 0x10 in bits 7:0, class code bytes 0x02, 0x00, 0x07 in bits 15:8, 23:16 and 31:24.
- R4: The base register at offset 0x10 resets to 0x00000001; a write with all four byte enables stores the write data ORed with the two low bits already held.
- R5: A full write of 0xFFFFFFFF to a live base register stores 0xFFFFFFF8 ORed with the two held low bits, so it reads 0xFFFFFFF9 from reset.
- R6: A base register write whose byte enables are not all set leaves the register unchanged.
- R7: With NUM_PORTS=2 the base register at offset 0x14 behaves as R4 to R6, independently of the one at 0x10; with NUM_PORTS=1 it reads zero after any write.
- R8: The dwords at offsets 0x18, 0x1C and 0x20 read zero after any write.
- R9: The dword at offset 0x3C reads {16'h0000, 8'h01, line}; line resets to 0x00 and takes write data bits 7:0 when byte enable bit 0 is set; the 0x01 pin byte ignores writes.
- R10: The capability pointer at offset 0x34 and all other offsets without a rule read their reset value (zero) regardless of writes; offsets at or above 0x100 read zero and their writes change nothing.
- R11: A read request raises rvalid_o for exactly the next cycle with the addressed dword on rdata_o; offset bits 1:0 and read byte enables are ignored, and rvalid_o stays low after writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_off_i | input | ADDR_W | Byte offset into configuration space |
| req_wdata_i | input | 32 | Write data, little-endian dword |
| req_be_i | input | 4 | Byte enables for writes |
| rdata_o | output | 32 | Read data, little-endian dword |
| rvalid_o | output | 1 | Read data valid, one cycle after a read |

## Verification
The bench probes the base registers with all-ones writes and then with ordinary writes whose low bits are set, so a design that replaced instead of merging the type bits, or kept the all-ones value, shows a wrong readback. It issues partial-enable base writes, writes to the pin byte, the command dword and the unused base slots, and aliased writes above 0x100 whose low bits match a base register; a design decoding too few offset bits or honouring those writes would corrupt a live register. A single-port instance runs alongside the dual-port one on the same stimulus, so a second base register that stores data when absent is caught.

// File: rtl/cfg_space_pkg.sv
`timescale 1ns/1ps
package cfg_space_pkg;
  localparam logic [31:0] ID_WORD    = 32'h3253_4348;
  localparam logic [15:0] CMD_RST    = 16'h0001;
  localparam logic [15:0] STS_RST    = 16'h0200;
  localparam logic [7:0]  REV_ID     = 8'h10;
  localparam logic [23:0] CLASS_CODE = 24'h07_00_02;
  localparam logic [7:0]  INT_PIN    = 8'h01;
  localparam int          MAX_BARS   = 2;

  typedef enum logic [5:0] {
    DW_ID     = 6'd0,
    DW_CMDSTS = 6'd1,
    DW_CLASS  = 6'd2,
    DW_BAR0   = 6'd4,
    DW_BAR1   = 6'd5,
    DW_SUBSYS = 6'd11,
    DW_INTR   = 6'd15
  } cfg_dw_e;
endpackage

// File: rtl/cfg_bar_slot.sv
`timescale 1ns/1ps
module cfg_bar_slot #(
  parameter int BAR_BYTES = 8,
  parameter bit PRESENT   = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [3:0]  be_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] bar_o
);
  localparam logic [31:0] SIZE_MASK = ~(32'(BAR_BYTES) - 32'd1);
  localparam logic [31:0] RST_VAL   = 32'h0000_0001;

  if (PRESENT) begin : g_live
    logic [31:0] bar_q;
    logic [31:0] wr_val;

    always_comb begin
      wr_val = (wdata_i == 32'hFFFF_FFFF) ? SIZE_MASK : wdata_i;
      wr_val = wr_val | {30'b0, bar_q[1:0]};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    bar_q <= RST_VAL;
      else if (wr_i && &be_i)         bar_q <= wr_val;
    end

    assign bar_o = bar_q;

    p_probe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && &be_i && wdata_i == 32'hFFFF_FFFF)
        |=> bar_o == (SIZE_MASK | {30'b0, $past(bar_o[1:0])}));

    p_partial_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !(&be_i)) |=> $stable(bar_o));

    p_type_kept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i |=> bar_o[0]);
  end else begin : g_absent
    logic unused_in;
    assign unused_in = ^{clk_i, rst_ni, wr_i, be_i, wdata_i};
    assign bar_o = '0;
  end
endmodule

// File: rtl/cfg_rd_path.sv
`timescale 1ns/1ps
module cfg_rd_path
  import cfg_space_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rd_i,
  input  logic        in_range_i,
  input  logic [5:0]  dw_i,
  input  logic [31:0] bar0_i,
  input  logic [31:0] bar1_i,
  input  logic [7:0]  int_line_i,
  output logic [31:0] rdata_o,
  output logic        rvalid_o
);
  logic [31:0] word;

  always_comb begin
    word = '0;
    if (in_range_i) begin
      unique case (dw_i)
        DW_ID, DW_SUBSYS: word = ID_WORD;
        DW_CMDSTS:        word = {STS_RST, CMD_RST};
        DW_CLASS:         word = {CLASS_CODE, REV_ID};
        DW_BAR0:          word = bar0_i;
        DW_BAR1:          word = bar1_i;
        DW_INTR:          word = {16'h0000, INT_PIN, int_line_i};
        default:          word = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= word;
    end
  end

  p_rvalid_next_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o);

  p_rvalid_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rvalid_o);

  p_cmdsts_fixed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && in_range_i && dw_i == DW_CMDSTS) |=> rdata_o == 32'h0200_0001);

  p_pin_fixed_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && in_range_i && dw_i == DW_INTR) |=> rdata_o[31:8] == 24'h00_0001);

  p_high_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !in_range_i) |=> rdata_o == 32'h0);
endmodule

// File: rtl/cfg_space_resp.sv
`timescale 1ns/1ps
module cfg_space_resp
  import cfg_space_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int ADDR_W    = 12,
  parameter int BAR_BYTES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_off_i,
  input  logic [31:0]       req_wdata_i,
  input  logic [3:0]        req_be_i,
  output logic [31:0]       rdata_o,
  output logic              rvalid_o
);
  localparam int HI_W = ADDR_W - 8;

  logic        in_range;
  logic [5:0]  dw;
  logic        wr, rd;
  logic [31:0] bar_w [MAX_BARS];
  logic [7:0]  int_line_q;
  logic        unused_lsb;

  assign unused_lsb = ^req_off_i[1:0];
  assign in_range   = (req_off_i[ADDR_W-1:8] == HI_W'(0));
  assign dw         = req_off_i[7:2];
  assign wr         = req_valid_i && req_we_i && in_range;
  assign rd         = req_valid_i && !req_we_i;

  for (genvar i = 0; i < MAX_BARS; i++) begin : g_bar
    cfg_bar_slot #(
      .BAR_BYTES (BAR_BYTES),
      .PRESENT   (i < NUM_PORTS)
    ) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr && dw == 6'(DW_BAR0) + 6'(i)),
      .be_i    (req_be_i),
      .wdata_i (req_wdata_i),
      .bar_o   (bar_w[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  int_line_q <= '0;
    else if (wr && dw == DW_INTR && req_be_i[0])  int_line_q <= req_wdata_i[7:0];
  end

  cfg_rd_path u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_i       (rd),
    .in_range_i (in_range),
    .dw_i       (dw),
    .bar0_i     (bar_w[0]),
    .bar1_i     (bar_w[1]),
    .int_line_i (int_line_q),
    .rdata_o    (rdata_o),
    .rvalid_o   (rvalid_o)
  );

  p_line_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && dw == DW_INTR && req_be_i[0]) |=> $stable(int_line_q));

  if (NUM_PORTS < 2) begin : g_one_port_chk
    p_bar1_absent_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd && in_range && dw == DW_BAR1) |=> rdata_o == 32'h0);
  end
endmodule

// File: tb/sim_cfg_space_resp.sv
`timescale 1ns/1ps
module sim_cfg_space_resp;
  localparam int ADDR_W = 12;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_we = 1'b0;
  logic [ADDR_W-1:0] req_off = '0;
  logic [31:0]       req_wdata = '0;
  logic [3:0]        req_be = '0;
  logic [31:0]       rdata2, rdata1;
  logic              rvalid2, rvalid1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] m_bar0, m_bar1;
  logic [7:0]  m_line;

  always #2.5 clk = ~clk;

  cfg_space_resp #(.NUM_PORTS(2), .ADDR_W(ADDR_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_we_i(req_we),
    .req_off_i(req_off), .req_wdata_i(req_wdata), .req_be_i(req_be),
    .rdata_o(rdata2), .rvalid_o(rvalid2));

  cfg_space_resp #(.NUM_PORTS(1), .ADDR_W(ADDR_W)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_we_i(req_we),
    .req_off_i(req_off), .req_wdata_i(req_wdata), .req_be_i(req_be),
    .rdata_o(rdata1), .rvalid_o(rvalid1));

  function automatic logic [31:0] exp_rd(input logic [ADDR_W-1:0] off, input bit two);
    logic [5:0] d;
    d = off[7:2];
    if (off >= 12'h100) return 32'h0;             // R10
    case (d)
      6'd0, 6'd11: return 32'h3253_4348;          // R1
      6'd1:        return 32'h0200_0001;          // R2
      6'd2:        return 32'h0700_0210;          // R3
      6'd4:        return m_bar0;                 // R4
      6'd5:        return two ? m_bar1 : 32'h0;   // R7
      6'd15:       return {16'h0, 8'h01, m_line}; // R9
      default:     return 32'h0;                  // R8 R10
    endcase
  endfunction

  function automatic logic [31:0] bar_upd(input logic [31:0] old, input logic [31:0] wd);
    logic [31:0] v;
    v = (wd == 32'hFFFF_FFFF) ? 32'hFFFF_FFF8 : wd;
    return v | {30'b0, old[1:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [ADDR_W-1:0] off, input logic [31:0] wd, input logic [3:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_off = off; req_wdata = wd; req_be = be;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
    chk("R11 no rvalid after write", {30'b0, rvalid2, rvalid1}, 32'h0);
    if (off < 12'h100) begin
      if (off[7:2] == 6'd4 && be == 4'hF) m_bar0 = bar_upd(m_bar0, wd);
      if (off[7:2] == 6'd5 && be == 4'hF) m_bar1 = bar_upd(m_bar1, wd);
      if (off[7:2] == 6'd15 && be[0])     m_line = wd[7:0];
    end
  endtask

  task automatic cfg_rd(input string tag, input logic [ADDR_W-1:0] off, input logic [3:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_off = off; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " rvalid R11"}, {30'b0, rvalid2, rvalid1}, 32'h3);
    chk({tag, " two-port"}, rdata2, exp_rd(off, 1'b1));
    chk({tag, " one-port"}, rdata1, exp_rd(off, 1'b0));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL R11 watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h1357_2468);
    m_bar0 = 32'h1; m_bar1 = 32'h1; m_line = 8'h0;
    repeat (3) @(negedge clk);
    chk("R11 reset rvalid low", {30'b0, rvalid2, rvalid1}, 32'h0);
    chk("R11 reset rdata zero", rdata2, 32'h0);
    rst_ni = 1'b1;

    // reset contents
    cfg_rd("R1 id",         12'h000, 4'hF);
    cfg_rd("R1 subsys",     12'h02C, 4'h0);
    cfg_rd("R2 cmd/status", 12'h004, 4'hF);
    cfg_rd("R3 class/rev",  12'h00B, 4'h1);
    cfg_rd("R4 bar0 reset", 12'h010, 4'hF);
    cfg_rd("R7 bar1 reset", 12'h014, 4'hF);
    cfg_rd("R9 intr reset", 12'h03C, 4'hF);
    cfg_rd("R10 cap ptr",   12'h034, 4'hF);
    @(negedge clk);
    chk("R11 idle rvalid low", {30'b0, rvalid2, rvalid1}, 32'h0);

    // directed write rules
    cfg_wr(12'h004, 32'h0000_0007, 4'hF);
    cfg_rd("R2 cmd write ignored", 12'h004, 4'hF);
    cfg_wr(12'h010, 32'hFFFF_FFFF, 4'hF);
    cfg_rd("R5 bar0 probe", 12'h010, 4'hF);
    chk("R5 probe value", rdata2, 32'hFFFF_FFF9);
    cfg_wr(12'h010, 32'h0000_C002, 4'hF);
    cfg_rd("R4 bar0 merge type bits", 12'h010, 4'hF);
    chk("R4 merged value", rdata2, 32'h0000_C003);
    cfg_wr(12'h010, 32'h1234_5670, 4'h7);
    cfg_rd("R6 partial bar0 ignored", 12'h010, 4'hF);
    cfg_wr(12'h014, 32'h0000_D000, 4'hF);
    cfg_rd("R7 bar1 write", 12'h014, 4'hF);
    cfg_rd("R7 bar0 independent", 12'h010, 4'hF);
    cfg_wr(12'h014, 32'hFFFF_FFFF, 4'hF);
    cfg_rd("R7 bar1 probe", 12'h014, 4'hF);
    cfg_wr(12'h018, 32'hDEAD_BEEF, 4'hF);
    cfg_wr(12'h01C, 32'hFFFF_FFFF, 4'hF);
    cfg_wr(12'h020, 32'h0000_0101, 4'hF);
    cfg_rd("R8 bar2 zero", 12'h018, 4'hF);
    cfg_rd("R8 bar3 zero", 12'h01C, 4'hF);
    cfg_rd("R8 bar4 zero", 12'h020, 4'hF);
    cfg_wr(12'h03C, 32'hFFFF_FF5A, 4'hF);
    cfg_rd("R9 line write, pin kept", 12'h03C, 4'hF);
    cfg_wr(12'h03C, 32'h0000_00A5, 4'hE);
    cfg_rd("R9 line be0 clear ignored", 12'h03C, 4'hF);
    cfg_wr(12'h034, 32'h0000_0040, 4'hF);
    cfg_rd("R10 cap ptr write ignored", 12'h034, 4'hF);
    cfg_wr(12'h110, 32'h0BAD_0000, 4'hF);
    cfg_rd("R10 alias write ignored", 12'h010, 4'hF);
    cfg_rd("R10 high read zero", 12'h110, 4'hF);
    cfg_rd("R10 top read zero", 12'hFFC, 4'hF);

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [ADDR_W-1:0] off;
      logic [31:0] wd;
      logic [3:0] be;
      if ($urandom % 8 == 0) off = 12'h100 + ADDR_W'($urandom % 12'hF00);
      else off = ADDR_W'(($urandom % 18) * 4 + ($urandom % 4));
      wd = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
      be = ($urandom % 2 == 0) ? 4'hF : 4'($urandom);
      if ($urandom % 2 == 0) cfg_wr(off, wd, be);
      else cfg_rd("R11 random read", off, be);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule